// File: doc/BRIEF.md
# Prefetch Line-Tag Filter

This block sits between a hardware prefetch address generator and the first-level data cache tag array. It keeps a small fully associative set of the line tags that were most recently sent on towards the cache. Every prefetch request is compared against this set before it can cost a cache tag lookup. A request whose line is already in the set is discarded, on the assumption that the line is still resident. A request whose line is not in the set is passed on to the cache tag lookup, and its line tag is recorded.

Replacement is least recently used, and both a recorded miss and a hit make the touched line the most recent. The block never learns of cache evictions, so a drop can be wrong now and then. That loss is accepted in exchange for fewer tag lookups. Two event counters report how many requests were dropped and how many were forwarded.

Top module: `pf_filter_buf`

## Requirements
- R1: After reset, fwd_valid and drop_valid are low, both counters read zero and the buffer holds no tags, so the first request after reset is forwarded.
- R2: The line tag is req_addr with its low log2(LINE_BYTES) bits removed (bits 31:5 with the defaults). Two addresses in the same 32-byte line share a tag, and addresses in adjacent lines do not.
- R3: A request accepted on a clock edge whose tag is absent is presented on fwd_valid/fwd_addr, with the original address, starting the cycle after acceptance.
- R4: A request accepted whose tag is present raises drop_valid for exactly one cycle after acceptance, with drop_addr equal to the request address, and it is not forwarded.
- R5: A forwarded request records its tag as most recent. Up to DEPTH (8) distinct tags are retained, and a repeat of any of them is dropped.
- R6: When the buffer is full, a new tag replaces the least recently used tag, and a later request to the replaced line is forwarded again.
- R7: A hit promotes the matching tag to most recent, so it survives the next replacement.
- R8: req_ready is high exactly when fwd_valid is low or fwd_ready is high. While fwd_valid is high and fwd_ready is low, fwd_valid and fwd_addr hold.
- R9: drop_cnt and fwd_cnt each advance by one, in the cycle when drop_valid or a new forward appears.
- R10: Each accepted request yields exactly one outcome, a drop or a forward, and drop_valid is never high together with fwd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Prefetch request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W | Prefetch byte address |
| fwd_valid | output | 1 | Request forwarded to the cache tag lookup |
| fwd_ready | input | 1 | Cache tag lookup takes the forwarded request |
| fwd_addr | output | ADDR_W | Forwarded address |
| drop_valid | output | 1 | One-cycle pulse: a request was discarded |
| drop_addr | output | ADDR_W | Address of the discarded request |
| drop_cnt | output | CNT_W | Number of dropped requests |
| fwd_cnt | output | CNT_W | Number of forwarded requests |

## Verification
The embedded properties assume only that reset is asserted before the first request. Requests may be withdrawn or changed while not accepted, and fwd_ready may toggle freely. The stimulus therefore mixes stable directed sequences with a random phase in which req_valid, req_addr and fwd_ready change every cycle. Addresses are confined to a dozen lines around one base, so hits, promotions and replacements all occur often in the full buffer, and stalls on the forwarded output occur as well.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_FWD  = 2'd1,
    OUT_DROP = 2'd2
  } pfb_outcome_e;
endpackage

// File: rtl/pfb_tag_store.sv
module pfb_tag_store #(
  parameter int TAG_W = 27,
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [DEPTH-1:0] hit_vec
);
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_mem[g] == look_tag);
  end

  // Tags are written only on a miss, so no tag is ever held twice.
  assert_unique_tag_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/pfb_lru_rank.sv
module pfb_lru_rank #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] rank_q [DEPTH];
  logic [IDX_W-1:0] touch_rank;
  logic [DEPTH-1:0] newest_vec;
  logic [DEPTH-1:0] oldest_vec;

  assign touch_rank = rank_q[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IDX_W'(i) == touch_idx) rank_q[i] <= '0;
        else if (rank_q[i] < touch_rank) rank_q[i] <= rank_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      newest_vec[i] = (rank_q[i] == '0);
      oldest_vec[i] = (rank_q[i] == OLDEST);
      if (oldest_vec[i]) victim_idx = IDX_W'(i);
    end
  end

  // Ranks stay a permutation: one newest entry and one replacement victim.
  assert_rank_perm_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(newest_vec) == 1) && ($countones(oldest_vec) == 1));
  // A touched entry becomes the newest one.
  assert_touch_newest_R7: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> newest_vec[$past(touch_idx)]);
endmodule

// File: rtl/pfb_event_counters.sv
module pfb_event_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_drop,
  input  logic             inc_fwd,
  output logic [CNT_W-1:0] drop_cnt,
  output logic [CNT_W-1:0] fwd_cnt
);
  localparam int NUM_EV = 2;

  logic [NUM_EV-1:0]            inc_vec;
  logic [NUM_EV-1:0][CNT_W-1:0] cnt_q;

  assign inc_vec = {inc_fwd, inc_drop};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else if (inc_vec[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign drop_cnt = cnt_q[0];
  assign fwd_cnt  = cnt_q[1];
endmodule

// File: rtl/pf_filter_buf.sv
module pf_filter_buf
  import pfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              drop_valid,
  output logic [ADDR_W-1:0] drop_addr,
  output logic [CNT_W-1:0]  drop_cnt,
  output logic [CNT_W-1:0]  fwd_cnt
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic [TAG_W-1:0] req_tag;
  logic [DEPTH-1:0] hit_vec;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] victim_idx;
  logic [IDX_W-1:0] touch_idx;
  logic             accept;
  pfb_outcome_e     outcome;

  logic              fwd_valid_q;
  logic [ADDR_W-1:0] fwd_addr_q;
  logic              drop_valid_q;
  logic [ADDR_W-1:0] drop_addr_q;

  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign req_ready = !fwd_valid_q || fwd_ready;
  assign accept    = req_valid && req_ready;
  assign any_hit   = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (!accept) outcome = OUT_NONE;
    else if (any_hit) outcome = OUT_DROP;
    else outcome = OUT_FWD;
  end

  assign touch_idx = any_hit ? hit_idx : victim_idx;

  pfb_tag_store #(.TAG_W(TAG_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .look_tag (req_tag),
    .wr_en    (outcome == OUT_FWD),
    .wr_idx   (victim_idx),
    .wr_tag   (req_tag),
    .hit_vec  (hit_vec)
  );

  pfb_lru_rank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (accept),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx)
  );

  pfb_event_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inc_drop (outcome == OUT_DROP),
    .inc_fwd  (outcome == OUT_FWD),
    .drop_cnt (drop_cnt),
    .fwd_cnt  (fwd_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid_q  <= 1'b0;
      drop_valid_q <= 1'b0;
    end else begin
      drop_valid_q <= (outcome == OUT_DROP);
      if (outcome == OUT_FWD) fwd_valid_q <= 1'b1;
      else if (fwd_ready) fwd_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (outcome == OUT_FWD) fwd_addr_q <= req_addr;
    if (outcome == OUT_DROP) drop_addr_q <= req_addr;
  end

  assign fwd_valid  = fwd_valid_q;
  assign fwd_addr   = fwd_addr_q;
  assign drop_valid = drop_valid_q;
  assign drop_addr  = drop_addr_q;

  assert_fwd_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)));
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> !fwd_valid);
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (drop_valid || fwd_valid));
  assert_drop_counted_R9: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> (drop_cnt == $past(drop_cnt) + 1'b1));
endmodule

// File: tb/pf_filter_buf_test.sv
`timescale 1ns/1ps
module pf_filter_buf_test;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam logic [AW-1:0] BASE = 32'h0000_4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          fwd_valid;
  logic          fwd_ready = 1'b1;
  logic [AW-1:0] fwd_addr;
  logic          drop_valid;
  logic [AW-1:0] drop_addr;
  logic [CW-1:0] drop_cnt;
  logic [CW-1:0] fwd_cnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pf_filter_buf uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .drop_valid(drop_valid), .drop_addr(drop_addr),
    .drop_cnt(drop_cnt), .fwd_cnt(fwd_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] line(input int n);
    return BASE + AW'(n * 32);
  endfunction

  // Behavioural reference: queue of line tags, newest at the front.
  logic [26:0]   m_q[$];
  bit            m_fv, m_dv;
  logic [AW-1:0] m_fa, m_da;
  int            m_fc, m_dc;

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete();
      m_fv = 0; m_dv = 0; m_fa = '0; m_da = '0; m_fc = 0; m_dc = 0;
    end else begin
      bit rdy;
      int found;
      rdy = !m_fv || fwd_ready;
      if (m_fv && fwd_ready) m_fv = 0;
      m_dv = 0;
      if (req_valid && rdy) begin
        found = -1;
        for (int i = 0; i < m_q.size(); i++)
          if (m_q[i] == req_addr[31:5]) found = i;
        if (found >= 0) begin
          m_q.delete(found);
          m_q.push_front(req_addr[31:5]);
          m_dv = 1; m_da = req_addr; m_dc++;
        end else begin
          m_q.push_front(req_addr[31:5]);
          if (m_q.size() > 8) void'(m_q.pop_back());
          m_fv = 1; m_fa = req_addr; m_fc++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(fwd_valid == m_fv, "R3", "fwd_valid", fwd_valid, m_fv);
      if (m_fv) chk(fwd_addr == m_fa, "R3", "fwd_addr", fwd_addr, m_fa);
      chk(drop_valid == m_dv, "R4", "drop_valid", drop_valid, m_dv);
      if (m_dv) chk(drop_addr == m_da, "R4", "drop_addr", drop_addr, m_da);
      chk(req_ready == (!m_fv || fwd_ready), "R8", "req_ready", req_ready,
          (!m_fv || fwd_ready));
      chk(drop_cnt == CW'(m_dc), "R9", "drop_cnt", drop_cnt, m_dc);
      chk(fwd_cnt == CW'(m_fc), "R9", "fwd_cnt", fwd_cnt, m_fc);
      chk(!(drop_valid && fwd_valid), "R10", "overlap", drop_valid, 0);
    end
  end

  task automatic probe(input logic [AW-1:0] a, input bit exp_drop,
                       input string req);
    @(posedge clk); #1 req_valid = 1'b1; req_addr = a;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(drop_valid == exp_drop, req, "drop outcome", drop_valid, exp_drop);
    chk(fwd_valid == !exp_drop, req, "fwd outcome", fwd_valid, !exp_drop);
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5.0 * 60000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: quiet outputs and zero counters after reset
    chk(!fwd_valid && !drop_valid, "R1", "valids", {fwd_valid, drop_valid}, 0);
    chk(drop_cnt == 0 && fwd_cnt == 0, "R1", "counters", {drop_cnt, fwd_cnt}, 0);

    probe(line(0), 0, "R1");        // empty buffer forwards
    probe(line(0) + 31, 1, "R2");   // same 32-byte line
    probe(line(1), 0, "R2");        // adjacent line differs
    for (int n = 2; n < 8; n++) probe(line(n), 0, "R3");
    for (int n = 0; n < 8; n++) probe(line(n) + 4, 1, "R5");
    probe(line(8), 0, "R6");        // evicts line 0
    probe(line(0), 0, "R6");        // line 0 was evicted, evicts line 1
    probe(line(2), 1, "R7");        // promote line 2
    probe(line(9), 0, "R7");        // evicts line 3, not line 2
    probe(line(2), 1, "R7");
    probe(line(3), 0, "R7");
    chk(fwd_cnt == 12, "R9", "fwd_cnt directed", fwd_cnt, 12);
    chk(drop_cnt == 11, "R9", "drop_cnt directed", drop_cnt, 11);

    // R8: stall on the forwarded output
    @(posedge clk); #1 fwd_ready = 1'b0; req_valid = 1'b1; req_addr = line(20);
    @(posedge clk); #1 req_addr = line(21);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fwd_valid && fwd_addr == line(20), "R8", "held fwd_addr", fwd_addr, line(20));
      chk(!req_ready, "R8", "req_ready stalled", req_ready, 0);
    end
    @(posedge clk); #1 fwd_ready = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk(fwd_valid && fwd_addr == line(21), "R8", "next fwd_addr", fwd_addr, line(21));

    // Mixed random traffic over a dozen lines, compared with the model
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      req_valid = ($urandom % 4) != 0;
      req_addr  = line($urandom % 12) + AW'($urandom % 32);
      fwd_ready = ($urandom % 3) != 0;
    end
    @(posedge clk); #1 req_valid = 1'b0; fwd_ready = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule